// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block decides when a memory controller must send an AUTO REFRESH command to a DDR SDRAM. It keeps the long-run refresh spacing at or below the 15.625 µs average limit. Individual refreshes may still be postponed while the controller is busy, or brought forward while it is quiet. An interval timer counts qualified clock ticks. Each time a full interval elapses, it adds one unit of refresh debt to a signed credit counter. Every refresh that the command arbiter grants pays off one unit. The counter saturates at a positive cap of eight units. While it sits at that cap, an urgent flag tells the arbiter that the refresh has to go out next. The counter may go negative down to a configurable floor, so that refreshes issued early are credited against later intervals.

Each refresh is a single explicit command. The scheduler drives no address, because the device ignores the address during AUTO REFRESH. A small state machine sequences each refresh through three named states:
- `ST_IDLE`: no request is pending.
- `ST_REQ`: the request is raised and waits for a grant.
- `ST_RFC`: the refresh cycle time is running after a grant.

The state machine takes the following named transitions:
- IDLE→REQ when refresh is wanted and all banks are idle.
- REQ→IDLE when either condition drops.
- REQ→RFC on an accepted grant.
- RFC→IDLE when the refresh cycle counter expires.

The clock-enable output is held low in reset and high from the first clock after reset onward. This keeps CKE high through every refresh period.

Top module: `rfsh_sched`

## Requirements
- R1: During reset `rf_req_o`, `rf_busy_o`, `rf_urgent_o` and `cke_o` are all 0. In the first cycle after reset is released, `rf_req_o` and `rf_busy_o` are 0 and `cke_o` is 1.
- R2: Every `TREF_CYC` cycles with `tick_en_i` = 1 add one unit of debt. With banks idle, `rf_req_o` rises in the second cycle after the clock edge that completes the interval.
- R3: `rf_req_o` is raised and held only while `bank_idle_i` = 1. If `bank_idle_i` falls, `rf_req_o` drops at the next edge. A grant given while `bank_idle_i` = 0 starts no refresh.
- R4: An accepted grant (`rf_grant_i` = 1 while `rf_req_o` = 1 and banks idle) makes `rf_busy_o` 1 for exactly `TRFC_CYC` cycles, starting at the next edge. `rf_req_o` stays 0 throughout.
- R5: Each accepted grant lowers the debt by one. With N units owed and `pull_in_i` = 0, exactly N refreshes are requested, and no more.
- R6: Debt saturates at `DEBT_MAX`. `rf_urgent_o` is 1 exactly while the debt equals `DEBT_MAX`. Further intervals at the cap add nothing, so at most `DEBT_MAX` refreshes follow.
- R7: With `pull_in_i` = 1, refreshes are requested while the debt is above `-PULLIN_MAX`. The debt never goes below `-PULLIN_MAX`, and later intervals first repay the pulled-in refreshes.
- R8: `cke_o` stays 1 in every cycle after reset, including every cycle in which `rf_busy_o` = 1.
- R9: Cycles with `tick_en_i` = 0 do not advance the interval timer.
- R10: A grant given while `rf_req_o` = 0 is ignored: `rf_busy_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en_i | input | 1 | Qualified timebase tick; each high cycle advances the interval timer |
| bank_idle_i | input | 1 | 1 when every bank is precharged and idle |
| pull_in_i | input | 1 | Controller is quiet; permits refreshing ahead of schedule |
| rf_grant_i | input | 1 | Arbiter grant of the pending refresh request |
| rf_req_o | output | 1 | Refresh request to the command arbiter |
| rf_urgent_o | output | 1 | Debt is at its cap; the request must be granted next |
| rf_busy_o | output | 1 | Refresh cycle time running; no command to the device |
| cke_o | output | 1 | Clock enable to the device, held high after reset |

## Verification
The request is due two edges after the tick that completes an interval. The first of those edges is the debt register and the second is the state register, so the bench samples on the falling edge just after that second rising edge. It also checks that the request is still low one sample earlier. `rf_busy_o` is due on the first edge after an accepted grant. The bench counts the falling-edge samples in which it is high and compares the count with `TRFC_CYC`. The debt is never read directly. It is inferred by serving requests until none appears within a window longer than the idle-to-request latency, and counting the refreshes that were served.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    // Refresh sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RFC  = 2'd2
    } rfsh_state_e;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
    parameter int unsigned TREF_CYC = 1953
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en_i,
    output logic period_o
);
    import rfsh_pkg::*;

    localparam int unsigned CW = cnt_width(TREF_CYC);

    generate
        if (TREF_CYC <= 1) begin : g_every
            // Degenerate interval: each qualified tick is a full period.
            assign period_o = tick_en_i;
        end else begin : g_count
            localparam logic [CW-1:0] LAST = CW'(TREF_CYC - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (tick_en_i) begin
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                end
            end

            assign period_o = tick_en_i && (cnt_q == LAST);

            // R9: the timer holds still when no tick is present
            p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !tick_en_i |=> cnt_q == $past(cnt_q));

            // R2: the timer never leaves its range
            p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= LAST);
        end
    endgenerate

endmodule

// File: rtl/rfsh_credit.sv
module rfsh_credit #(
    parameter int unsigned DEBT_MAX   = 8,
    parameter int unsigned PULLIN_MAX = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic period_i,
    input  logic take_i,
    output logic owed_o,
    output logic may_pull_o,
    output logic at_cap_o
);
    import rfsh_pkg::*;

    localparam int unsigned DW = cnt_width(DEBT_MAX + PULLIN_MAX + 1) + 2;
    localparam logic signed [DW-1:0] CAP   = DW'(DEBT_MAX);
    localparam logic signed [DW-1:0] FLOOR = -(DW'(PULLIN_MAX));
    localparam logic signed [DW-1:0] ONE   = DW'(1);
    localparam logic signed [DW-1:0] ZERO  = '0;

    logic signed [DW-1:0] debt_q;
    logic signed [DW-1:0] debt_d;

    always_comb begin
        debt_d = debt_q;
        if (take_i) begin
            debt_d = debt_d - ONE;
        end
        if (period_i && !((debt_q == CAP) && !take_i)) begin
            debt_d = debt_d + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            debt_q <= ZERO;
        end else begin
            debt_q <= debt_d;
        end
    end

    assign owed_o     = debt_q > ZERO;
    assign may_pull_o = debt_q > FLOOR;
    assign at_cap_o   = debt_q == CAP;

    // R6: debt never exceeds the cap
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        debt_q <= CAP);

    // R7: debt never drops below the pull-in floor
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        debt_q >= FLOOR);

    // R5: a grant with no concurrent period pays off exactly one unit
    p_take_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !period_i) |=> debt_q == $past(debt_q) - ONE);

    // R2: a period below the cap with no grant adds exactly one unit
    p_period_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i && !take_i && debt_q != CAP) |=> debt_q == $past(debt_q) + ONE);

    // R7: a grant is only ever taken while above the floor
    p_take_above_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> debt_q > FLOOR);

endmodule

// File: rtl/rfsh_fsm.sv
module rfsh_fsm #(
    parameter int unsigned TRFC_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_i,
    input  logic bank_idle_i,
    input  logic grant_i,
    output logic req_o,
    output logic busy_o,
    output logic take_o
);
    import rfsh_pkg::*;

    localparam int unsigned TW = cnt_width(TRFC_CYC);
    localparam logic [TW-1:0] RFC_LAST = TW'((TRFC_CYC > 0) ? TRFC_CYC - 1 : 0);

    rfsh_state_e st_q, st_d;
    logic [TW-1:0] rfc_q;
    logic          accept;

    assign accept = (st_q == ST_REQ) && grant_i && bank_idle_i && want_i;

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (want_i && bank_idle_i) st_d = ST_REQ;
            ST_REQ: begin
                if (accept) begin
                    st_d = ST_RFC;
                end else if (!want_i || !bank_idle_i) begin
                    st_d = ST_IDLE;
                end
            end
            ST_RFC:  if (rfc_q == '0) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register and refresh cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            rfc_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                rfc_q <= RFC_LAST;
            end else if (st_q == ST_RFC && rfc_q != '0) begin
                rfc_q <= rfc_q - 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        req_o  = 1'b0;
        busy_o = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_REQ:  req_o  = 1'b1;
            ST_RFC:  busy_o = 1'b1;
            default: ;
        endcase
    end

    assign take_o = accept;

    // R3: a request is only ever raised on an idle-bank cycle
    p_req_needs_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(bank_idle_i));

    // R4: an accepted grant starts the refresh period at the next edge
    p_grant_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_o);

    // R4: the refresh period ends when the counter expires
    p_rfc_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && rfc_q == '0) |=> !busy_o);

    // R4: the refresh period cannot end early
    p_rfc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && rfc_q != '0) |=> busy_o);

    // R4: no request while a refresh is running
    p_no_req_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_o && busy_o));

    // R10: a grant without a request starts nothing
    p_stray_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_i && !req_o && !busy_o) |=> !busy_o);

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
    parameter int unsigned TREF_CYC   = 1953,
    parameter int unsigned DEBT_MAX   = 8,
    parameter int unsigned PULLIN_MAX = 2,
    parameter int unsigned TRFC_CYC   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en_i,
    input  logic bank_idle_i,
    input  logic pull_in_i,
    input  logic rf_grant_i,
    output logic rf_req_o,
    output logic rf_urgent_o,
    output logic rf_busy_o,
    output logic cke_o
);

    logic period;
    logic take;
    logic owed;
    logic may_pull;
    logic at_cap;
    logic want;
    logic cke_q;

    rfsh_interval #(
        .TREF_CYC (TREF_CYC)
    ) u_interval (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en_i (tick_en_i),
        .period_o  (period)
    );

    rfsh_credit #(
        .DEBT_MAX   (DEBT_MAX),
        .PULLIN_MAX (PULLIN_MAX)
    ) u_credit (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_i   (period),
        .take_i     (take),
        .owed_o     (owed),
        .may_pull_o (may_pull),
        .at_cap_o   (at_cap)
    );

    // A refresh is wanted when owed, or early when the controller allows it.
    assign want = owed || (pull_in_i && may_pull);

    rfsh_fsm #(
        .TRFC_CYC (TRFC_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .want_i      (want),
        .bank_idle_i (bank_idle_i),
        .grant_i     (rf_grant_i),
        .req_o       (rf_req_o),
        .busy_o      (rf_busy_o),
        .take_o      (take)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q <= 1'b0;
        end else begin
            cke_q <= 1'b1;
        end
    end

    assign cke_o       = cke_q;
    assign rf_urgent_o = rst_n && at_cap;

    // R8: clock enable is high whenever a refresh is running
    p_cke_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_busy_o |-> cke_o);

    // R8: once high, clock enable stays high until reset
    p_cke_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cke_o |=> cke_o);

    // R6: urgency only ever comes with something owed
    p_urgent_owed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_urgent_o |-> owed);

endmodule

// File: tb/test_rfsh_sched.sv
module test_rfsh_sched;

    localparam int TREF  = 20;
    localparam int DMAX  = 8;
    localparam int PMAX  = 2;
    localparam int TRFC  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic bank_idle = 1'b0;
    logic pull_in = 1'b0;
    logic grant = 1'b0;
    logic rf_req, rf_urgent, rf_busy, cke;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    rfsh_sched #(
        .TREF_CYC   (TREF),
        .DEBT_MAX   (DMAX),
        .PULLIN_MAX (PMAX),
        .TRFC_CYC   (TRFC)
    ) i_rfsh_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en_i   (tick_en),
        .bank_idle_i (bank_idle),
        .pull_in_i   (pull_in),
        .rf_grant_i  (grant),
        .rf_req_o    (rf_req),
        .rf_urgent_o (rf_urgent),
        .rf_busy_o   (rf_busy),
        .cke_o       (cke)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick_en = 1'b0; bank_idle = 1'b0; pull_in = 1'b0; grant = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    // Serve requests until none appears; checks each busy window (R4, R8).
    task automatic serve_all(output int served);
        bit found;
        int bc;
        served = 0;
        forever begin
            found = 1'b0;
            for (int w = 0; w < TRFC + 4; w++) begin
                if (rf_req) begin
                    found = 1'b1;
                    break;
                end
                @(negedge clk);
            end
            if (!found) break;
            grant = 1'b1;
            @(negedge clk);
            grant = 1'b0;
            bc = 0;
            while (rf_busy && bc < 100) begin
                bc++;
                if (rf_req) check(1'b0, "R4 req during busy", 1, 0);
                if (!cke) check(1'b0, "R8 cke during busy", 0, 1);
                @(negedge clk);
            end
            check(bc == TRFC, "R4 busy length", bc, TRFC);
            served++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(!rf_req && !rf_busy && !rf_urgent, "R1 outputs in reset",
              {rf_req, rf_busy, rf_urgent}, 0);
        check(cke == 1'b0, "R1 cke in reset", cke, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cke == 1'b1, "R1 cke after reset", cke, 1);
        check(!rf_req && !rf_busy, "R1 idle after reset", {rf_req, rf_busy}, 0);
    endtask

    task automatic t_interval();
        int n;
        do_reset();
        bank_idle = 1'b1;
        run_ticks(TREF - 1);
        @(negedge clk);
        check(rf_req == 1'b0, "R2 no req before full interval", rf_req, 0);
        run_ticks(1);
        check(rf_req == 1'b0, "R2 req not yet at debt edge", rf_req, 0);
        @(negedge clk);
        check(rf_req == 1'b1, "R2 req two edges after interval", rf_req, 1);
        serve_all(n);
        check(n == 1, "R2 one refresh per interval", n, 1);
    endtask

    task automatic t_no_tick();
        do_reset();
        bank_idle = 1'b1;
        repeat (3 * TREF) @(negedge clk);
        check(rf_req == 1'b0, "R9 no tick no request", rf_req, 0);
        run_ticks(TREF - 1);
        @(negedge clk);
        check(rf_req == 1'b0, "R9 idle cycles did not advance timer", rf_req, 0);
    endtask

    task automatic t_bank_busy();
        int n;
        do_reset();
        run_ticks(TREF);
        repeat (3) @(negedge clk);
        check(rf_req == 1'b0, "R3 no req while banks busy", rf_req, 0);
        grant = 1'b1;
        @(negedge clk);
        grant = 1'b0;
        @(negedge clk);
        check(rf_busy == 1'b0, "R3 grant ignored while banks busy", rf_busy, 0);
        bank_idle = 1'b1;
        @(negedge clk);
        check(rf_req == 1'b1, "R3 req after banks idle", rf_req, 1);
        bank_idle = 1'b0;
        @(negedge clk);
        check(rf_req == 1'b0, "R3 req drops with bank activity", rf_req, 0);
        bank_idle = 1'b1;
        serve_all(n);
        check(n == 1, "R3 debt kept while withdrawn", n, 1);
    endtask

    task automatic t_multi_debt();
        int n;
        do_reset();
        run_ticks(3 * TREF);
        bank_idle = 1'b1;
        serve_all(n);
        check(n == 3, "R5 three owed three served", n, 3);
    endtask

    task automatic t_cap();
        int n;
        do_reset();
        run_ticks((DMAX + 3) * TREF);
        @(negedge clk);
        check(rf_urgent == 1'b1, "R6 urgent at cap", rf_urgent, 1);
        bank_idle = 1'b1;
        serve_all(n);
        check(n == DMAX, "R6 debt saturates at cap", n, DMAX);
        check(rf_urgent == 1'b0, "R6 urgent clears", rf_urgent, 0);
    endtask

    task automatic t_pull_in();
        int n;
        do_reset();
        bank_idle = 1'b1;
        pull_in = 1'b1;
        serve_all(n);
        check(n == PMAX, "R7 pull-in limited by floor", n, PMAX);
        pull_in = 1'b0;
        run_ticks(PMAX * TREF);
        repeat (3) @(negedge clk);
        check(rf_req == 1'b0, "R7 early refreshes repaid first", rf_req, 0);
        run_ticks(TREF);
        serve_all(n);
        check(n == 1, "R7 normal after repayment", n, 1);
    endtask

    task automatic t_stray_grant();
        do_reset();
        bank_idle = 1'b1;
        grant = 1'b1;
        repeat (2) @(negedge clk);
        grant = 1'b0;
        check(rf_busy == 1'b0, "R10 grant without request ignored", rf_busy, 0);
        check(cke == 1'b1, "R8 cke high after reset", cke, 1);
    endtask

    initial begin
        t_reset();
        t_interval();
        t_no_tick();
        t_bank_busy();
        t_multi_debt();
        t_cap();
        t_pull_in();
        t_stray_grant();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule